// File: doc/BRIEF.md
# Reservation Line Cache

This block is a small direct-mapped cache that sits in front of a pixel or colour buffer. A client never touches a line implicitly. It first claims the line through the allocation port, either as a fetch, which loads the line from memory, or as an allocate, which claims the line without loading it. It then reads the line, and finally frees the claim with a plain or byte-masked write or with an explicit unreserve. A claimed line is never evicted. When a claimed slot holds modified data for another address, that data is sent to memory before the slot is reused.

Requests leave through one memory request output, at most one per cycle, taken from an internal queue. Line data returns through a read-data input that is used only when a response is present. A flush command only raises a flag. While the flag is up, the cache writes back one modified, unclaimed line per cycle, and the flag drops once no modified line remains. Claims are granted in order. After a fetch or allocate has been refused, every other fetch or allocate is refused until the refused one is presented again and granted. A clear command returns all line state to empty.

Top module: `rfc_top`

## Requirements
- R1: An accepted fetch whose line is absent claims the slot and queues a read request (mem_req_write=0) for that line address. The line gives rd_ok=0 until it is filled.
- R2: When an accepted fetch or allocate replaces a slot that holds modified data for another line, the cache first emits a write request (mem_req_write=1) carrying the old line address and the full 128-bit line, and only then emits any read request. Requests appear one per cycle, in queue order.
- R3: An accepted allocate of an absent line claims the slot, issues no read request, and the line then reads as all zeros.
- R4: A read of a present, filled line returns rd_ok=1 and the 32-bit word selected by rd_addr[1:0] one cycle later. A read of any other line returns rd_ok=0.
- R5: A write to a claimed, filled line with a matching tag sets byte i of word wr_addr[1:0] (line bits 32w+8i+7..32w+8i) from wr_data[8i+7:8i] only where wr_mask[i]=1. It marks the line modified and frees the claim. A write to an unclaimed line is ignored.
- R6: Unreserve (alloc_op=2) is always accepted. It frees the claim on a matching line and leaves its data unchanged.
- R7: A flush command (cmd_op=0) raises flush_active. While it is raised, the lowest-indexed modified, unclaimed line is written back each cycle. Claimed modified lines wait until they are freed, and flush_active falls once no modified line remains.
- R8: A memory response fills a line only if its line address matches a line that is waiting for fill. Any other response is ignored.
- R9: After a fetch or allocate (alloc_op 0 or 1) is refused, every fetch or allocate with a different opcode or line address is refused until the refused request is accepted.
- R10: A fetch or allocate whose slot is claimed, by the same line or by an aliasing line, is refused.
- R11: A clear command (cmd_op=1), like reset, empties every line, drops all claims, modified marks, pending fills, the flush flag and the refusal record.
- R12: A fetch of a present, unclaimed line claims it without any memory request and keeps its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 flush, 1 clear |
| alloc_valid | input | 1 | Allocation request strobe |
| alloc_op | input | 2 | 0 fetch, 1 allocate, 2 unreserve |
| alloc_line | input | 12 | Line address of the request |
| alloc_accept | output | 1 | Request granted in this cycle |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 14 | Word address (line address, word select) |
| wr_data | input | 32 | Write data |
| wr_mask | input | 4 | Byte enables, all ones for a plain write |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | 14 | Word address to read |
| rd_ok | output | 1 | Read result valid, one cycle after rd_valid |
| rd_data | output | 32 | Read word |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 writeback, 0 line read |
| mem_req_line | output | 12 | Line address of the request |
| mem_req_data | output | 128 | Writeback data, zero for reads |
| mem_rsp_valid | input | 1 | Read data arrives |
| mem_rsp_line | input | 12 | Line address of the returned data |
| mem_rsp_data | input | 128 | Returned line |
| flush_active | output | 1 | Flush flag |

## Verification
The bench aims at the refusal chain. It refuses an aliasing fetch and then offers an unrelated fetch to a free slot, which must also be refused. A design that granted requests out of order would grant that second fetch and let it overtake the first. It also sends a mismatched fill to a pending slot, which a careless design would accept as valid data. A flush is run while one modified line is still claimed: a wrong design would either write that claimed line back or drop the flag early. A clear is issued with a dirty line and a refusal both outstanding, where a leaky design would emit a stale writeback or keep refusing.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
   typedef enum logic [1:0] {
      OP_FETCH = 2'd0,
      OP_ALLOC = 2'd1,
      OP_UNRES = 2'd2
   } alloc_op_e;

   localparam logic CMD_FLUSH = 1'b0;
   localparam logic CMD_CLEAR = 1'b1;
endpackage

// File: rtl/rfc_pick.sv
module rfc_pick #(
   parameter int N = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/rfc_memq.sv
module rfc_memq #(
   parameter int DEPTH = 4,
   parameter int ENT_W = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push0,
   input  logic [ENT_W-1:0] ent0,
   input  logic             push1,
   input  logic [ENT_W-1:0] ent1,
   output logic             out_valid,
   output logic [ENT_W-1:0] out_ent,
   output logic [CNT_W-1:0] free
);
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("rfc_memq: DEPTH must be a power of two, at least 2");
   end

   logic [ENT_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt, n_push;

   assign n_push    = CNT_W'(push0) + CNT_W'(push1);
   assign out_valid = (cnt != '0);
   assign out_ent   = slot[rd_ptr];
   assign free      = CNT_W'(DEPTH) - cnt;

   always_ff @(posedge clk) begin
      if (push0) slot[wr_ptr] <= ent0;
      if (push1) slot[wr_ptr + PTR_W'(push0)] <= ent1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         cnt    <= cnt + n_push - CNT_W'(out_valid);
         wr_ptr <= wr_ptr + PTR_W'(n_push);
         rd_ptr <= rd_ptr + PTR_W'(out_valid);
      end
   end

   // R2: the controller never pushes more entries than there is room for
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      n_push <= free);
endmodule

// File: rtl/rfc_data.sv
module rfc_data #(
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 16,
   parameter int WORD_BYTES = 4,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WORDS  = LINE_BYTES / WORD_BYTES,
   localparam int WSEL_W = $clog2(WORDS),
   localparam int LINE_W = LINE_BYTES * 8,
   localparam int WORD_W = WORD_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  fill_en,
   input  logic [IDX_W-1:0]      fill_idx,
   input  logic [LINE_W-1:0]     fill_line,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [WSEL_W-1:0]     wr_word,
   input  logic [WORD_W-1:0]     wr_data,
   input  logic [WORD_BYTES-1:0] wr_be,
   input  logic                  zero_en,
   input  logic [IDX_W-1:0]      zero_idx,
   input  logic [IDX_W-1:0]      a_idx,
   output logic [LINE_W-1:0]     a_line,
   input  logic [IDX_W-1:0]      b_idx,
   input  logic [WSEL_W-1:0]     b_word,
   output logic [WORD_W-1:0]     b_data
);
   if (WORDS < 2) begin : g_bad_words
      $error("rfc_data: a line must hold at least two words");
   end

   logic [LINE_W-1:0] mem [LINES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LINES; i++) begin
         if (zero_en && zero_idx == IDX_W'(i)) begin
            mem[i] <= '0;
         end else if (fill_en && fill_idx == IDX_W'(i)) begin
            mem[i] <= fill_line;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
               if (wr_be[b]) mem[i][int'(wr_word) * WORD_W + b * 8 +: 8] <= wr_data[b * 8 +: 8];
            end
         end
      end
   end

   assign a_line = mem[a_idx];
   assign b_data = mem[b_idx][int'(b_word) * WORD_W +: WORD_W];
endmodule

// File: rtl/rfc_top.sv
module rfc_top
   import rfc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 16,
   parameter int QDEPTH     = 4,
   localparam int WORD_BYTES = 4,
   localparam int OFF_W   = $clog2(LINE_BYTES),
   localparam int IDX_W   = $clog2(LINES),
   localparam int LADDR_W = ADDR_W - OFF_W,
   localparam int TAG_W   = LADDR_W - IDX_W,
   localparam int WSEL_W  = OFF_W - 2,
   localparam int WADDR_W = ADDR_W - 2,
   localparam int LINE_W  = LINE_BYTES * 8,
   localparam int ENT_W   = 1 + LADDR_W + LINE_W,
   localparam int CNT_W   = $clog2(QDEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_op,
   input  logic               alloc_valid,
   input  logic [1:0]         alloc_op,
   input  logic [LADDR_W-1:0] alloc_line,
   output logic               alloc_accept,
   input  logic               wr_valid,
   input  logic [WADDR_W-1:0] wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [3:0]         wr_mask,
   input  logic               rd_valid,
   input  logic [WADDR_W-1:0] rd_addr,
   output logic               rd_ok,
   output logic [31:0]        rd_data,
   output logic               mem_req_valid,
   output logic               mem_req_write,
   output logic [LADDR_W-1:0] mem_req_line,
   output logic [LINE_W-1:0]  mem_req_data,
   input  logic               mem_rsp_valid,
   input  logic [LADDR_W-1:0] mem_rsp_line,
   input  logic [LINE_W-1:0]  mem_rsp_data,
   output logic               flush_active
);
   if ((1 << OFF_W) != LINE_BYTES || LINE_BYTES < 8) begin : g_bad_line
      $error("rfc_top: LINE_BYTES must be a power of two, at least 8");
   end
   if ((1 << IDX_W) != LINES || LINES < 2 || TAG_W < 1) begin : g_bad_lines
      $error("rfc_top: LINES must be a power of two that leaves tag bits");
   end

   // line state
   logic [LINES-1:0] vld, drt, rsv, pnd;
   logic [TAG_W-1:0] tag_q [LINES];
   logic             flush_q, wait_q;
   logic [1:0]       wait_op_q;
   logic [LADDR_W-1:0] wait_line_q;

   // allocation port decode
   logic [IDX_W-1:0] a_idx;
   logic [TAG_W-1:0] a_tag;
   logic clear_now, is_res, a_hit, order_ok, res_ok, unres_hit;
   logic need_wb, need_rd, zero_en;
   logic [CNT_W-1:0] q_free;

   assign a_idx     = alloc_line[IDX_W-1:0];
   assign a_tag     = alloc_line[LADDR_W-1:IDX_W];
   assign clear_now = cmd_valid && cmd_op == CMD_CLEAR;
   assign is_res    = alloc_valid && (alloc_op == OP_FETCH || alloc_op == OP_ALLOC);
   assign a_hit     = vld[a_idx] && tag_q[a_idx] == a_tag;
   assign order_ok  = !wait_q || (wait_line_q == alloc_line && wait_op_q == alloc_op);
   assign res_ok    = is_res && !rsv[a_idx] && !pnd[a_idx] && order_ok
                      && q_free >= CNT_W'(2) && !clear_now;
   assign unres_hit = alloc_valid && alloc_op == OP_UNRES && a_hit && rsv[a_idx] && !clear_now;
   assign alloc_accept = res_ok || (alloc_valid && alloc_op == OP_UNRES && !clear_now);
   assign need_wb   = res_ok && !a_hit && vld[a_idx] && drt[a_idx];
   assign need_rd   = res_ok && !a_hit && alloc_op == OP_FETCH;
   assign zero_en   = res_ok && !a_hit && alloc_op == OP_ALLOC;

   // write port decode
   logic [LADDR_W-1:0] w_line;
   logic [IDX_W-1:0]   w_idx;
   logic               wr_ok;
   assign w_line = wr_addr[WADDR_W-1:WSEL_W];
   assign w_idx  = w_line[IDX_W-1:0];
   assign wr_ok  = wr_valid && vld[w_idx] && rsv[w_idx] && !pnd[w_idx]
                   && tag_q[w_idx] == w_line[LADDR_W-1:IDX_W] && !clear_now;

   // fill decode
   logic [IDX_W-1:0] f_idx;
   logic             fill_ok;
   assign f_idx   = mem_rsp_line[IDX_W-1:0];
   assign fill_ok = mem_rsp_valid && vld[f_idx] && pnd[f_idx]
                    && tag_q[f_idx] == mem_rsp_line[LADDR_W-1:IDX_W] && !clear_now;

   // read decode
   logic [LADDR_W-1:0] r_line;
   logic [IDX_W-1:0]   r_idx;
   logic               rd_hit;
   logic [31:0]        r_word_data;
   assign r_line = rd_addr[WADDR_W-1:WSEL_W];
   assign r_idx  = r_line[IDX_W-1:0];
   assign rd_hit = rd_valid && vld[r_idx] && !pnd[r_idx]
                   && tag_q[r_idx] == r_line[LADDR_W-1:IDX_W] && !clear_now;

   // flush victim selection
   logic             fl_found, fl_go, any_dirty;
   logic [IDX_W-1:0] fl_idx, v_idx;
   assign any_dirty = |(vld & drt);

   rfc_pick #(.N(LINES)) u_pick (
      .req   (vld & drt & ~rsv & ~pnd),
      .found (fl_found),
      .idx   (fl_idx)
   );

   assign fl_go = flush_q && fl_found && !res_ok && q_free >= CNT_W'(1) && !clear_now;
   assign v_idx = res_ok ? a_idx : fl_idx;

   // data array and request queue
   logic [LINE_W-1:0] v_line;
   logic [ENT_W-1:0]  q_out;

   rfc_data #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_data (
      .clk       (clk),
      .fill_en   (fill_ok),
      .fill_idx  (f_idx),
      .fill_line (mem_rsp_data),
      .wr_en     (wr_ok),
      .wr_idx    (w_idx),
      .wr_word   (wr_addr[WSEL_W-1:0]),
      .wr_data   (wr_data),
      .wr_be     (wr_mask),
      .zero_en   (zero_en),
      .zero_idx  (a_idx),
      .a_idx     (v_idx),
      .a_line    (v_line),
      .b_idx     (r_idx),
      .b_word    (rd_addr[WSEL_W-1:0]),
      .b_data    (r_word_data)
   );

   rfc_memq #(.DEPTH(QDEPTH), .ENT_W(ENT_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push0     (need_wb || fl_go),
      .ent0      ({1'b1, tag_q[v_idx], v_idx, v_line}),
      .push1     (need_rd),
      .ent1      ({1'b0, alloc_line, {LINE_W{1'b0}}}),
      .out_valid (mem_req_valid),
      .out_ent   (q_out),
      .free      (q_free)
   );

   assign mem_req_write = q_out[ENT_W-1];
   assign mem_req_line  = q_out[LINE_W +: LADDR_W];
   assign mem_req_data  = q_out[LINE_W-1:0];
   assign flush_active  = flush_q;

   // line state update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0; drt <= '0; rsv <= '0; pnd <= '0;
         flush_q <= 1'b0; wait_q <= 1'b0;
         wait_op_q <= '0; wait_line_q <= '0;
      end else if (clear_now) begin
         vld <= '0; drt <= '0; rsv <= '0; pnd <= '0;
         flush_q <= 1'b0; wait_q <= 1'b0;
      end else begin
         if (res_ok) begin
            rsv[a_idx] <= 1'b1;
            if (!a_hit) begin
               vld[a_idx] <= 1'b1;
               drt[a_idx] <= 1'b0;
               pnd[a_idx] <= (alloc_op == OP_FETCH);
            end
         end
         if (unres_hit) rsv[a_idx] <= 1'b0;
         if (wr_ok) begin
            drt[w_idx] <= 1'b1;
            rsv[w_idx] <= 1'b0;
         end
         if (fill_ok) pnd[f_idx] <= 1'b0;
         if (fl_go) drt[fl_idx] <= 1'b0;
         if (cmd_valid && cmd_op == CMD_FLUSH) flush_q <= 1'b1;
         else if (flush_q && !any_dirty)      flush_q <= 1'b0;
         if (is_res && !res_ok && !wait_q) begin
            wait_q      <= 1'b1;
            wait_op_q   <= alloc_op;
            wait_line_q <= alloc_line;
         end else if (res_ok) begin
            wait_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (res_ok && !a_hit) tag_q[a_idx] <= a_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_ok <= 1'b0;
      else        rd_ok <= rd_hit;
   end

   always_ff @(posedge clk) rd_data <= r_word_data;

   // R1: a granted fetch of an absent line puts a request on the memory port next cycle
   p_fetch_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_accept && alloc_op == OP_FETCH && !a_hit) |=> mem_req_valid);

   // R4: a read result only follows a read strobe
   p_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ok |-> $past(rd_valid));

   // R5: a taken write frees the claim of its line
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> !rsv[$past(w_idx)]);

   // R8: a matching response ends the pending fill
   p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ok |=> !pnd[$past(f_idx)]);

   // R7: the flush flag only falls without a clear once no modified line is left
   p_flush_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(flush_q) && !$past(clear_now)) |-> !$past(any_dirty));

   // R10: a granted claim leaves its slot claimed
   p_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_accept && alloc_op != OP_UNRES) |=> rsv[$past(a_idx)]);
endmodule

// File: tb/sim_rfc_top.sv
`timescale 1ns/1ps
module sim_rfc_top;
   localparam int LA = 12;
   localparam int LW = 128;
   localparam int EW = 1 + LA + LW;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, cmd_valid, cmd_op, alloc_valid, alloc_accept;
   logic [1:0] alloc_op;
   logic [LA-1:0] alloc_line, mem_req_line, mem_rsp_line;
   logic wr_valid, rd_valid, rd_ok, mem_req_valid, mem_req_write, mem_rsp_valid, flush_active;
   logic [LA+1:0] wr_addr, rd_addr;
   logic [31:0] wr_data, rd_data;
   logic [3:0] wr_mask;
   logic [LW-1:0] mem_req_data, mem_rsp_data;

   rfc_top u0 (.*);

   int checks = 0;
   int errors = 0;
   logic [EW-1:0] exp_q[$];
   string         exp_r[$];

   task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // scoreboard monitor for the memory request port
   initial begin
      logic [EW-1:0] e;
      string r;
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1 && mem_req_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R2 request order: actual %h expected none",
                        {mem_req_write, mem_req_line, mem_req_data});
            end else begin
               e = exp_q.pop_front();
               r = exp_r.pop_front();
               chk(r, {mem_req_write, mem_req_line, mem_req_data}, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   task automatic expect_req(bit w, logic [LA-1:0] l, logic [LW-1:0] d, string r);
      exp_q.push_back({w, l, d});
      exp_r.push_back(r);
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_alloc(logic [1:0] op, logic [LA-1:0] l, bit exp, string r);
      alloc_valid = 1'b1; alloc_op = op; alloc_line = l;
      @(negedge clk);
      chk(r, alloc_accept, exp);
      @(posedge clk); #1;
      alloc_valid = 1'b0;
   endtask

   task automatic do_write(logic [LA-1:0] l, logic [1:0] w, logic [31:0] d, logic [3:0] m);
      wr_valid = 1'b1; wr_addr = {l, w}; wr_data = d; wr_mask = m;
      @(posedge clk); #1;
      wr_valid = 1'b0;
   endtask

   task automatic do_read(logic [LA-1:0] l, logic [1:0] w, bit ok, logic [31:0] d, string r);
      rd_valid = 1'b1; rd_addr = {l, w};
      @(posedge clk); #1;
      rd_valid = 1'b0;
      @(negedge clk);
      chk(r, rd_ok, ok);
      if (ok) chk(r, rd_data, d);
      @(posedge clk); #1;
   endtask

   task automatic do_fill(logic [LA-1:0] l, logic [LW-1:0] d);
      mem_rsp_valid = 1'b1; mem_rsp_line = l; mem_rsp_data = d;
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0;
   endtask

   task automatic do_cmd(logic op);
      cmd_valid = 1'b1; cmd_op = op;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   localparam logic [LW-1:0] D1  = 128'h1f1e1d1c_1b1a1918_17161514_13121110;
   localparam logic [LW-1:0] D2  = 128'h2f2e2d2c_2b2a2928_27262524_23222120;
   localparam logic [LW-1:0] D2M = 128'h2f2e2d2c_2bbb29dd_27262524_23222120;
   localparam logic [LW-1:0] D3  = 128'h3f3e3d3c_3b3a3938_37363534_33323130;
   localparam logic [LW-1:0] D3M = 128'h3f3e3d3c_3b3a3938_37363534_33325678;
   localparam logic [LW-1:0] D1M = 128'h1f1e1d1c_1b1a1918_17161514_cafef00d;
   localparam logic [LW-1:0] DZ  = 128'h600dbeef_00000000_00000000_00000000;

   initial begin
      rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; alloc_valid = 0; alloc_op = 0; alloc_line = 0;
      wr_valid = 0; wr_addr = 0; wr_data = 0; wr_mask = 0; rd_valid = 0; rd_addr = 0;
      mem_rsp_valid = 0; mem_rsp_line = 0; mem_rsp_data = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset no request", mem_req_valid, 0);
      chk("R11 reset flush flag", flush_active, 0);
      chk("R11 reset read flag", rd_ok, 0);
      @(posedge clk); #1;

      // R1 / R8: fetch miss, pending line, wrong and right fill
      expect_req(0, 12'h001, '0, "R1 fetch read request");
      do_alloc(2'd0, 12'h001, 1, "R1 fetch accepted");
      do_read(12'h001, 2'd0, 0, '0, "R1 pending line not readable");
      do_fill(12'h081, D2);
      do_read(12'h001, 2'd0, 0, '0, "R8 mismatched fill ignored");
      do_fill(12'h001, D1);
      do_read(12'h001, 2'd1, 1, 32'h17161514, "R4 read filled word");

      // R10 / R9 / R6: aliasing refusal and in-order acceptance
      do_alloc(2'd0, 12'h081, 0, "R10 aliasing fetch refused");
      do_alloc(2'd0, 12'h002, 0, "R9 later fetch refused");
      do_alloc(2'd2, 12'h001, 1, "R6 unreserve accepted");
      do_read(12'h001, 2'd1, 1, 32'h17161514, "R6 data kept after unreserve");
      do_alloc(2'd0, 12'h002, 0, "R9 still refused while first waits");
      expect_req(0, 12'h081, '0, "R9 waiting fetch read request");
      do_alloc(2'd0, 12'h081, 1, "R9 waiting fetch accepted");
      expect_req(0, 12'h002, '0, "R9 later fetch read request");
      do_alloc(2'd0, 12'h002, 1, "R9 later fetch accepted");
      do_fill(12'h081, D2);
      do_fill(12'h002, D3);

      // R5: masked write, then write to a released line is ignored
      do_write(12'h081, 2'd2, 32'haabbccdd, 4'b0101);
      do_read(12'h081, 2'd2, 1, 32'h2bbb29dd, "R5 masked bytes");
      do_write(12'h081, 2'd2, 32'h55555555, 4'b1111);
      do_read(12'h081, 2'd2, 1, 32'h2bbb29dd, "R5 write to released line ignored");

      // R2: dirty victim written back before the read
      expect_req(1, 12'h081, D2M, "R2 victim writeback");
      expect_req(0, 12'h001, '0, "R2 read after writeback");
      do_alloc(2'd0, 12'h001, 1, "R2 fetch over dirty line");
      do_fill(12'h001, D1);
      do_write(12'h001, 2'd0, 32'hcafef00d, 4'b1111);

      // R3: allocate over dirty line, no read, zeroed
      expect_req(1, 12'h001, D1M, "R3 allocate writeback");
      do_alloc(2'd1, 12'h101, 1, "R3 allocate accepted");
      do_read(12'h101, 2'd0, 1, 32'h0, "R3 allocated line reads zero");
      do_write(12'h101, 2'd3, 32'h600dbeef, 4'b1111);

      // R12: fetch hit needs no memory traffic
      do_alloc(2'd0, 12'h101, 1, "R12 fetch hit accepted");
      do_read(12'h101, 2'd3, 1, 32'h600dbeef, "R12 hit keeps data");
      do_alloc(2'd2, 12'h101, 1, "R6 unreserve after hit");

      // R7: flush skips a claimed dirty line until it is freed
      do_write(12'h002, 2'd0, 32'h12345678, 4'b0011);
      do_alloc(2'd0, 12'h002, 1, "R12 refetch dirty line");
      expect_req(1, 12'h101, DZ, "R7 flush writeback");
      do_cmd(1'b0);
      idle(4);
      chk("R7 flag held for claimed dirty line", flush_active, 1);
      expect_req(1, 12'h002, D3M, "R7 flush after release");
      do_alloc(2'd2, 12'h002, 1, "R6 unreserve during flush");
      idle(4);
      chk("R7 flag drops when clean", flush_active, 0);

      // R11: clear discards dirty state and the refusal record
      do_alloc(2'd1, 12'h003, 1, "R3 allocate line three");
      do_write(12'h003, 2'd1, 32'hdeadbeef, 4'b1111);
      do_alloc(2'd1, 12'h003, 1, "R12 allocate hit");
      do_alloc(2'd0, 12'h083, 0, "R10 aliasing refused");
      do_alloc(2'd0, 12'h005, 0, "R9 refused behind waiting one");
      do_cmd(1'b1);
      do_read(12'h003, 2'd1, 0, '0, "R11 cleared line absent");
      expect_req(0, 12'h005, '0, "R11 fetch after clear");
      do_alloc(2'd0, 12'h005, 1, "R11 refusal record cleared");
      expect_req(0, 12'h083, '0, "R11 no stale writeback");
      do_alloc(2'd0, 12'h083, 1, "R11 claim cleared");
      idle(6);
      chk("R2 all expected requests seen", exp_q.size(), 0);
      summary();
      $finish;
   end
endmodule